// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a 32-pin general-purpose output port whose control state sits in two banks of flip-flops. The first bank holds the output level used in GPIO mode. The second bank chooses, pin by pin, whether the pin carries that level or a signal from an on-chip peripheral. Software never writes either bank directly. Each bank has one address where a 1 in the written word forces the bit high, and another address where a 1 forces the bit low. A single write can therefore move any group of pins in the same direction without a read-modify-write sequence.

Each bank also has a read address that returns its present contents. The pin multiplexer is purely combinational. A peripheral reaches a pin only when that pin's select bit is 1, and the peripheral's own enable plays no part in this. Reset is asserted asynchronously and released through a two-stage synchronizer, so the port leaves reset two clock edges after `rst_n` rises.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset, both banks hold 0, `pin_out` is 0 and `bus_rdata` is 0.
- R2: A write to address 0x1 sets every level bit whose position in `bus_wdata` is 1 and leaves all other level bits as they were. The change is visible on the clock edge that samples the write.
- R3: A write to address 0x2 clears every level bit whose position in `bus_wdata` is 1 and leaves all other level bits as they were.
- R4: One set or clear write can change several bits at once, and a write of the all-zero word to any set or clear address changes nothing.
- R5: The select bank uses the same scheme as the level bank: address 0x5 sets bits and address 0x6 clears bits.
- R6: For each pin i, `pin_out[i]` equals level bit i when select bit i is 0, and equals `periph_in[i]` when select bit i is 1. It follows `periph_in` with no clock delay, and no peripheral enable is involved.
- R7: A read with `bus_rd_en` at address 0x0 returns the level bank, and a read at 0x4 returns the select bank. In both cases `bus_rdata` is updated on the sampling edge and keeps its value until the next read.
- R8: Writes to any address other than 0x1, 0x2, 0x5 and 0x6 are ignored, including writes to the read addresses 0x0 and 0x4. Reads from any address other than 0x0 and 0x4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd_en | input | 1 | Read strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data used as a set or clear mask |
| bus_rdata | output | 32 | Registered read data |
| periph_in | input | 32 | Per-pin peripheral signals |
| pin_out | output | 32 | Pin drive values |

## Verification
A write changes a bank on the edge that samples it. Since the pin multiplexer is combinational, `pin_out` shows the new value in the half-cycle that follows, and the bench checks it at the next falling edge. A read is captured on the edge that samples `bus_rd_en`. The driver queues the expected word when it issues the read, and the monitor pops that word and compares it at the falling edge one cycle later. A change on `periph_in` needs no clock at all, so it is checked within the same low phase in which it was applied.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_LVL_SET,
    ACC_LVL_CLR,
    ACC_SEL_SET,
    ACC_SEL_CLR,
    ACC_LVL_RD,
    ACC_SEL_RD
  } acc_kind_e;

  localparam logic [3:0] OFF_LVL_RD  = 4'h0;
  localparam logic [3:0] OFF_LVL_SET = 4'h1;
  localparam logic [3:0] OFF_LVL_CLR = 4'h2;
  localparam logic [3:0] OFF_SEL_RD  = 4'h4;
  localparam logic [3:0] OFF_SEL_SET = 4'h5;
  localparam logic [3:0] OFF_SEL_CLR = 4'h6;

  function automatic acc_kind_e decode_addr(input logic [3:0] a);
    case (a)
      OFF_LVL_RD:  decode_addr = ACC_LVL_RD;
      OFF_LVL_SET: decode_addr = ACC_LVL_SET;
      OFF_LVL_CLR: decode_addr = ACC_LVL_CLR;
      OFF_SEL_RD:  decode_addr = ACC_SEL_RD;
      OFF_SEL_SET: decode_addr = ACC_SEL_SET;
      OFF_SEL_CLR: decode_addr = ACC_SEL_CLR;
      default:     decode_addr = ACC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sc_rst_sync.sv
module gpio_sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_next;
  logic         q_en;

  always_comb begin
    q_en   = set_en | clr_en;
    q_next = q_r;
    if (set_en)      q_next = q_r | mask;
    else if (clr_en) q_next = q_r & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_next;
  end

  assign q = q_r;

endmodule

// File: rtl/gpio_sc_pinmux.sv
module gpio_sc_pinmux #(
  parameter int W = 32
) (
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] periph_in,
  output logic [W-1:0] pin_out
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_out[i] = sel[i] ? periph_in[i] : lvl[i];
  end

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
  import gpio_sc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] periph_in,
  output logic [DATA_W-1:0] pin_out
);

  logic              rst_sync_n;
  acc_kind_e         kind;
  logic              lvl_set, lvl_clr, sel_set, sel_clr;
  logic [DATA_W-1:0] data_q, fsel_q;
  logic [DATA_W-1:0] rdata_q, rdata_next;

  gpio_sc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    kind    = decode_addr(4'(bus_addr));
    lvl_set = bus_wr_en && (kind == ACC_LVL_SET);
    lvl_clr = bus_wr_en && (kind == ACC_LVL_CLR);
    sel_set = bus_wr_en && (kind == ACC_SEL_SET);
    sel_clr = bus_wr_en && (kind == ACC_SEL_CLR);
  end

  gpio_sc_bank #(.W(DATA_W)) u_lvl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_en(lvl_set),
    .clr_en(lvl_clr),
    .mask  (bus_wdata),
    .q     (data_q)
  );

  gpio_sc_bank #(.W(DATA_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_en(sel_set),
    .clr_en(sel_clr),
    .mask  (bus_wdata),
    .q     (fsel_q)
  );

  gpio_sc_pinmux #(.W(DATA_W)) u_mux (
    .lvl      (data_q),
    .sel      (fsel_q),
    .periph_in(periph_in),
    .pin_out  (pin_out)
  );

  always_comb begin
    case (kind)
      ACC_LVL_RD: rdata_next = data_q;
      ACC_SEL_RD: rdata_next = fsel_q;
      default:    rdata_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    rdata_q <= '0;
    else if (bus_rd_en) rdata_q <= rdata_next;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic              bus_rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] periph_in,
  input logic [DATA_W-1:0] pin_out,
  input logic [DATA_W-1:0] data_q,
  input logic [DATA_W-1:0] fsel_q
);

  logic undef_wr;
  assign undef_wr = bus_wr_en && !(bus_addr == 4'h1 || bus_addr == 4'h2 ||
                                   bus_addr == 4'h5 || bus_addr == 4'h6);

  a_r2_lvl_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 4'h1) |=>
      (data_q == ($past(data_q) | $past(bus_wdata))));

  a_r3_lvl_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 4'h2) |=>
      (data_q == ($past(data_q) & ~$past(bus_wdata))));

  a_r5_sel_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 4'h5) |=>
      (fsel_q == ($past(fsel_q) | $past(bus_wdata))));

  a_r5_sel_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 4'h6) |=>
      (fsel_q == ($past(fsel_q) & ~$past(bus_wdata))));

  a_r6_gpio_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel_q == '0) |-> (pin_out == data_q));

  a_r6_periph_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (&fsel_q) |-> (pin_out == periph_in));

  a_r7_read_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == 4'h0) |=> (bus_rdata == $past(data_q)));

  a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rdata));

  a_r8_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
    undef_wr |=> ($stable(data_q) && $stable(fsel_q)));

  a_r8_undef_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr != 4'h0 && bus_addr != 4'h4) |=> (bus_rdata == '0));

endmodule

bind gpio_sc_port gpio_sc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .periph_in(periph_in),
  .pin_out  (pin_out),
  .data_q   (data_q),
  .fsel_q   (fsel_q)
);

// File: tb/gpio_sc_port_tb_top.sv
`timescale 1ns/1ps
module gpio_sc_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en, bus_rd_en;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, periph_in, pin_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_lvl = '0;
  logic [31:0] m_sel = '0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];
  logic rd_seen = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_sc_port dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .periph_in(periph_in),
    .pin_out  (pin_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pins_model();
    return (m_lvl & ~m_sel) | (periph_in & m_sel);
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
    case (a)
      4'h1: m_lvl = m_lvl | d;
      4'h2: m_lvl = m_lvl & ~d;
      4'h5: m_sel = m_sel | d;
      4'h6: m_sel = m_sel & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [3:0] a, input string tag);
    rd_item_t it;
    it.tag = tag;
    it.exp = (a == 4'h0) ? m_lvl : (a == 4'h4) ? m_sel : 32'h0;
    exp_q.push_back(it);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= bus_rd_en;

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rd_seen) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7: read result with no queued item, actual %h expected none", bus_rdata);
        end else begin
          rd_item_t it;
          it = exp_q.pop_front();
          check(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] held;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    bus_addr = '0; bus_wdata = '0; periph_in = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 pins after reset", pin_out, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    bus_read(4'h0, "R1 level bank reset");
    bus_read(4'h4, "R1 select bank reset");

    bus_write(4'h1, 32'h0000_0300);
    check("R4 two bits in one set write, pins", pin_out, 32'h0000_0300);
    bus_read(4'h0, "R2 read after set");
    bus_write(4'h1, 32'hF000_0001);
    check("R2 set keeps other bits, pins", pin_out, 32'hF000_0301);
    bus_write(4'h2, 32'h0000_0101);
    check("R3 clear keeps other bits, pins", pin_out, 32'hF000_0200);
    bus_read(4'h0, "R3 read after clear");

    bus_write(4'h1, 32'h0);
    bus_write(4'h2, 32'h0);
    bus_write(4'h5, 32'h0);
    bus_write(4'h6, 32'h0);
    check("R4 zero writes change nothing, pins", pin_out, 32'hF000_0200);
    bus_read(4'h0, "R4 level unchanged by zero writes");
    bus_read(4'h4, "R4 select unchanged by zero writes");

    periph_in = 32'hA5A5_A5A5;
    #0.5;
    check("R6 gpio mode ignores periph", pin_out, 32'hF000_0200);
    @(negedge clk);
    bus_write(4'h5, 32'h0000_0F0F);
    check("R5 select set, pins mix", pin_out, pins_model());
    bus_read(4'h4, "R5 read select after set");
    periph_in = 32'h5A5A_5A5A;
    #0.5;
    check("R6 pins follow periph without clock", pin_out, pins_model());
    @(negedge clk);
    bus_write(4'h6, 32'h0000_0300);
    check("R5 select clear, pins mix", pin_out, pins_model());
    bus_read(4'h4, "R5 read select after clear");
    bus_write(4'h5, 32'hFFFF_FFFF);
    check("R6 all pins from periph", pin_out, 32'h5A5A_5A5A);
    bus_write(4'h6, 32'hFFFF_FFFF);
    check("R6 all pins back to gpio", pin_out, m_lvl);

    bus_write(4'h3, 32'hFFFF_FFFF);
    bus_write(4'h7, 32'hFFFF_FFFF);
    bus_write(4'hF, 32'hFFFF_FFFF);
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_write(4'h4, 32'hFFFF_FFFF);
    check("R8 undefined writes ignored, pins", pin_out, 32'hF000_0200);
    bus_read(4'h0, "R8 level after undefined writes");
    bus_read(4'h4, "R8 select after undefined writes");
    bus_read(4'h1, "R8 read of set address is 0");
    bus_read(4'h6, "R8 read of clear address is 0");
    bus_read(4'h9, "R8 read of unmapped address is 0");

    bus_read(4'h0, "R7 level read before hold");
    held = m_lvl;
    bus_write(4'h1, 32'h0000_00FF);
    repeat (3) @(negedge clk);
    check("R7 rdata holds without read", bus_rdata, held);
    bus_read(4'h0, "R7 fresh read after set");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7: actual %0d reads unanswered expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule